// File: doc/BRIEF.md
# Masked Station Address Filter

This block sits behind a serial link receiver and decides, at the start of every frame, whether the frame is meant for this station. The receiver delivers de-stuffed bytes with a byte strobe, marks each new frame with a start strobe and signals the end of a frame with an end strobe. The filter collects the one or two leading address bytes and compares them against a programmed station address. Bits that are set in a programmable mask are left out of the compare, so the unit can accept group addresses. It can also accept every address (promiscuous mode). An address made only of ones is a broadcast and is accepted whatever the station address and mask hold.

A mode bit, captured at the start strobe, selects a one-byte or a two-byte address. In two-byte mode the first byte on the line is the low half of the address. The block gives a registered decision-valid flag and a registered match flag. Both stay unchanged until the next start strobe. A frame that ends before its address has fully arrived gives a valid "no match" decision. Downstream logic uses the flags to keep or drop the rest of the frame.

Top module: `staf_top`

## Requirements
- R1: After synchronous reset, `dec_vld_o` and `match_o` are both 0.
- R2: In one-byte mode (`wide_i` = 0 at the start strobe), `dec_vld_o` rises one clock after the first address byte. `match_o` is 1 exactly when every received bit at a position whose `mask_i` bit is 0 equals the matching `station_addr_i` bit, using bits [7:0]. A `mask_i` bit of 1 means "ignore this position".
- R3: In two-byte mode (`wide_i` = 1), the first byte is compared with bits [7:0] and the second with bits [15:8]. No decision is given after the first byte. `dec_vld_o` rises one clock after the second byte, and the masked compare covers all 16 bits.
- R4: In one-byte mode, a received byte of 8'hFF always gives `match_o` = 1.
- R5: In two-byte mode, only 16'hFFFF counts as broadcast and always matches. A low byte of 8'hFF with a different high byte is compared normally.
- R6: When every mask bit of the active width is 1, any address matches.
- R7: Once `dec_vld_o` is 1, it and `match_o` keep their values until the next start strobe. Later bytes and end strobes are ignored.
- R8: A start strobe without a byte clears `dec_vld_o` and `match_o` on the next clock. A start strobe arriving with a byte makes that byte the first address byte of the new frame.
- R9: An end strobe that arrives while address bytes are still expected gives `dec_vld_o` = 1 and `match_o` = 0 on the next clock.
- R10: The address width is the value of `wide_i` at the start strobe. Changes during the frame have no effect.
- R11: Bytes and end strobes seen before the first start strobe after reset are ignored, and `dec_vld_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-frame strobe, one cycle |
| eof_i | input | 1 | End-of-frame strobe, one cycle |
| byte_vld_i | input | 1 | Received byte valid strobe |
| byte_i | input | BYTE_W | Received byte |
| wide_i | input | 1 | 1 selects a two-byte address, sampled at the start strobe |
| station_addr_i | input | 2*BYTE_W | Programmed station address |
| mask_i | input | 2*BYTE_W | Per-bit compare mask, 1 = ignore |
| dec_vld_o | output | 1 | Decision available for the current frame |
| match_o | output | 1 | Frame is addressed to this station |

## Verification
Every one-byte address is swept against several station/mask pairs. These include a fully masked pair and a partly masked group pair, so a mask with the wrong polarity or on the wrong lane gives wrong results across the whole sweep. A long run of two-byte vectors checks that the byte order is low then high: a design with the halves swapped fails the near-miss cases. It also checks that a lone 8'hFF low byte does not count as a broadcast, and a design that tests broadcast on one byte only would accept those frames. Separate frames cover an early end of frame, a mode flip mid-frame, a start strobe that also carries a byte, extra bytes after the decision, and traffic before the first start. A design that decides too early, restarts on stray bytes or lets a later byte overwrite the result gives the wrong flags in those cases.

// File: rtl/staf_pkg.sv
package staf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_DONE = 2'd3
  } staf_state_t;
endpackage

// File: rtl/staf_collect.sv
module staf_collect
  import staf_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              wide_i,
  output logic              cand_fire_o,
  output logic              cand_short_o,
  output logic              cand_wide_o,
  output logic [ADDR_W-1:0] cand_addr_o
);
  staf_state_t st_q, st_d;
  logic              wide_q;
  logic [BYTE_W-1:0] lo_q;
  logic              take_lo, take_hi, wide_eff;

  always_comb begin
    wide_eff     = sof_i ? wide_i : wide_q;
    take_lo      = byte_vld_i && (sof_i || st_q == ST_LO);
    take_hi      = byte_vld_i && !sof_i && st_q == ST_HI;
    cand_fire_o  = (take_lo && !wide_eff) || take_hi;
    cand_short_o = eof_i && !byte_vld_i && !sof_i &&
                   (st_q == ST_LO || st_q == ST_HI);
    cand_wide_o  = take_hi;
    cand_addr_o  = take_hi ? {byte_i, lo_q} : {{BYTE_W{1'b0}}, byte_i};
  end

  always_comb begin
    st_d = st_q;
    if (sof_i) begin
      if (take_lo) st_d = wide_eff ? ST_HI : ST_DONE;
      else         st_d = ST_LO;
    end else if (take_lo) begin
      st_d = wide_eff ? ST_HI : ST_DONE;
    end else if (take_hi || cand_short_o) begin
      st_d = ST_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      wide_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      st_q <= st_d;
      if (sof_i)   wide_q <= wide_i;
      if (take_lo) lo_q   <= byte_i;
    end
  end

  // R3: waiting for a high byte only happens in a frame opened in wide mode
  assert_hi_only_wide_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HI) |-> wide_q);
  // R11: no candidate is produced before any frame has been opened
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !sof_i) |-> !(cand_fire_o || cand_short_o));
endmodule

// File: rtl/staf_compare.sv
module staf_compare #(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W,
  localparam int NLANE  = ADDR_W / BYTE_W
) (
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] cand_i,
  input  logic [ADDR_W-1:0] station_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              hit_o
);
  logic [NLANE-1:0] lane_eq;
  logic [NLANE-1:0] lane_ones;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [BYTE_W-1:0] rx, st, mk;
    assign rx = cand_i[g*BYTE_W +: BYTE_W];
    assign st = station_i[g*BYTE_W +: BYTE_W];
    assign mk = mask_i[g*BYTE_W +: BYTE_W];
    assign lane_eq[g]   = ((rx ^ st) & ~mk) == '0;
    assign lane_ones[g] = &rx;
  end

  always_comb begin
    if (wide_i) hit_o = (&lane_eq) || (&lane_ones);
    else        hit_o = lane_eq[0] || lane_ones[0];
  end
endmodule

// File: rtl/staf_top.sv
module staf_top #(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              dec_vld_o,
  output logic              match_o
);
  logic              cand_fire, cand_short, cand_wide, hit;
  logic [ADDR_W-1:0] cand_addr;

  staf_collect #(.BYTE_W(BYTE_W)) collect_i (
    .clk(clk), .rst(rst), .sof_i(sof_i), .eof_i(eof_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .wide_i(wide_i),
    .cand_fire_o(cand_fire), .cand_short_o(cand_short),
    .cand_wide_o(cand_wide), .cand_addr_o(cand_addr)
  );

  staf_compare #(.BYTE_W(BYTE_W)) compare_i (
    .wide_i(cand_wide), .cand_i(cand_addr), .station_i(station_addr_i),
    .mask_i(mask_i), .hit_o(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld_o <= 1'b0;
      match_o   <= 1'b0;
    end else if (cand_fire) begin
      dec_vld_o <= 1'b1;
      match_o   <= hit;
    end else if (cand_short) begin
      dec_vld_o <= 1'b1;
      match_o   <= 1'b0;
    end else if (sof_i) begin
      dec_vld_o <= 1'b0;
      match_o   <= 1'b0;
    end
  end

  // R2: a match is only reported together with a valid decision
  assert_match_qualified_R2: assert property (@(posedge clk) disable iff (rst)
    match_o |-> dec_vld_o);
  // R7: a decision holds until a new start strobe
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (dec_vld_o && !sof_i) |=> (dec_vld_o && $stable(match_o)));
  // R8: a bare start strobe withdraws the decision
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (sof_i && !byte_vld_i) |=> !dec_vld_o);
  // R9: a decision appears only after a byte or an end strobe
  assert_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_vld_o) |-> $past(byte_vld_i || eof_i));
endmodule

// File: tb/staf_top_tb_top.sv
module staf_top_tb_top;
  localparam int BW = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sof_i = 1'b0, eof_i = 1'b0, byte_vld_i = 1'b0, wide_i = 1'b0;
  logic [BW-1:0] byte_i = '0;
  logic [AW-1:0] station_addr_i = '0, mask_i = '0;
  logic          dec_vld_o, match_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  staf_top #(.BYTE_W(BW)) dut_i (
    .clk(clk), .rst(rst), .sof_i(sof_i), .eof_i(eof_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .wide_i(wide_i),
    .station_addr_i(station_addr_i), .mask_i(mask_i),
    .dec_vld_o(dec_vld_o), .match_o(match_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic bit exp_match(bit w, logic [AW-1:0] a, logic [AW-1:0] m,
                                   logic [AW-1:0] rx);
    if (w) return (rx == 16'hFFFF) || (((rx ^ a) & ~m) == 16'h0);
    return (rx[7:0] == 8'hFF) || (((rx[7:0] ^ a[7:0]) & ~m[7:0]) == 8'h0);
  endfunction

  task automatic chk(string req, logic dv, logic mt, logic edv, logic emt);
    n_vec = n_vec + 1;
    if (dv !== edv || mt !== emt) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual dec_vld=%b match=%b expected dec_vld=%b match=%b",
               req, dv, mt, edv, emt);
    end
  endtask

  task automatic idle_in();
    sof_i = 0; eof_i = 0; byte_vld_i = 0;
  endtask

  task automatic open_frame(bit w);
    @(negedge clk); idle_in(); sof_i = 1; wide_i = w;
  endtask

  task automatic put_byte(logic [BW-1:0] b);
    @(negedge clk); idle_in(); byte_vld_i = 1; byte_i = b;
  endtask

  task automatic quiet();
    @(negedge clk); idle_in();
  endtask

  task automatic frame8(string req, logic [BW-1:0] b);
    open_frame(1'b0);
    put_byte(b);
    quiet();
    chk(req, dec_vld_o, match_o, 1'b1,
        exp_match(1'b0, station_addr_i, mask_i, {8'h00, b}));
  endtask

  task automatic frame16(string req, logic [AW-1:0] rx);
    open_frame(1'b1);
    put_byte(rx[7:0]);
    put_byte(rx[15:8]);
    chk("R3 no early decision", dec_vld_o, match_o, 1'b0, 1'b0);
    quiet();
    chk(req, dec_vld_o, match_o, 1'b1,
        exp_match(1'b1, station_addr_i, mask_i, rx));
  endtask

  initial begin
    logic [31:0] s;
    logic [AW-1:0] sa [6];
    logic [AW-1:0] mk [6];
    repeat (3) @(negedge clk);
    chk("R1 reset", dec_vld_o, match_o, 1'b0, 1'b0);
    rst = 0;
    quiet();
    chk("R1 after reset", dec_vld_o, match_o, 1'b0, 1'b0);

    // R11: traffic before any start strobe
    station_addr_i = 16'h0042; mask_i = 16'h0000;
    put_byte(8'h42);
    put_byte(8'hFF);
    @(negedge clk); idle_in(); eof_i = 1;
    quiet();
    chk("R11 ignored before sof", dec_vld_o, match_o, 1'b0, 1'b0);

    // R2 R4 R6: exhaustive one-byte sweep
    sa[0] = 16'h1234; mk[0] = 16'h0000;
    sa[1] = 16'hAB5A; mk[1] = 16'h000F;
    sa[2] = 16'h00C3; mk[2] = 16'hFF81;
    sa[3] = 16'h0000; mk[3] = 16'h00FF;
    sa[4] = 16'hFF00; mk[4] = 16'hFF00;
    sa[5] = 16'h00FE; mk[5] = 16'h0000;
    for (int c = 0; c < 6; c++) begin
      station_addr_i = sa[c]; mask_i = mk[c];
      for (int b = 0; b < 256; b++) begin
        if (b == 255)            frame8("R4 broadcast byte", 8'(b));
        else if (mk[c][7:0] == 8'hFF) frame8("R6 promiscuous", 8'(b));
        else                     frame8("R2 masked compare", 8'(b));
      end
    end

    // R3 R5 R6: two-byte vectors
    station_addr_i = 16'h5A3C; mask_i = 16'h0000;
    frame16("R3 exact 16", 16'h5A3C);
    frame16("R3 halves swapped", 16'h3C5A);
    frame16("R5 full broadcast", 16'hFFFF);
    frame16("R5 low FF only", 16'h5AFF);
    frame16("R5 high FF only", 16'hFF3C);
    mask_i = 16'hFFFF;
    frame16("R6 promiscuous 16", 16'h1234);
    s = 32'h1F2E3D4C;
    for (int k = 0; k < 3000; k++) begin
      s = s * 32'd1103515245 + 32'd12345;
      station_addr_i = s[31:16];
      s = s * 32'd1103515245 + 32'd12345;
      mask_i = s[31:16] & s[15:0] & {s[7:0], s[15:8]};
      s = s * 32'd1103515245 + 32'd12345;
      if (k % 3 == 0)      frame16("R3 masked 16", station_addr_i ^ (mask_i & s[31:16]));
      else if (k % 3 == 1) frame16("R3 near miss", station_addr_i ^ (16'h1 << (s[19:16])));
      else                 frame16("R3 random 16", s[31:16]);
    end

    // R7: extra bytes and eof after a decision
    station_addr_i = 16'h0077; mask_i = 16'h0000;
    frame8("R2 set match", 8'h77);
    put_byte(8'h10);
    @(negedge clk); idle_in(); eof_i = 1;
    quiet();
    chk("R7 hold after extra byte", dec_vld_o, match_o, 1'b1, 1'b1);
    frame8("R2 set miss", 8'h10);
    put_byte(8'h77);
    quiet();
    chk("R7 hold miss", dec_vld_o, match_o, 1'b1, 1'b0);

    // R8: bare sof clears
    frame8("R2 set match", 8'h77);
    open_frame(1'b0);
    quiet();
    chk("R8 sof clears", dec_vld_o, match_o, 1'b0, 1'b0);
    // R8: sof carrying the first byte
    @(negedge clk); idle_in(); sof_i = 1; wide_i = 0; byte_vld_i = 1; byte_i = 8'h77;
    quiet();
    chk("R8 sof with byte", dec_vld_o, match_o, 1'b1, 1'b1);
    @(negedge clk); idle_in(); sof_i = 1; wide_i = 1; byte_vld_i = 1; byte_i = 8'h77;
    quiet();
    chk("R8 sof with wide low byte", dec_vld_o, match_o, 1'b0, 1'b0);
    put_byte(8'h00);
    quiet();
    chk("R8 wide after sof byte", dec_vld_o, match_o, 1'b1, 1'b1);

    // R9: early end of frame
    open_frame(1'b0);
    @(negedge clk); idle_in(); eof_i = 1;
    quiet();
    chk("R9 eof before byte", dec_vld_o, match_o, 1'b1, 1'b0);
    open_frame(1'b1);
    put_byte(8'hFF);
    @(negedge clk); idle_in(); eof_i = 1;
    quiet();
    chk("R9 eof after low half", dec_vld_o, match_o, 1'b1, 1'b0);

    // R10: mode flip inside a frame
    station_addr_i = 16'h1177; mask_i = 16'h0000;
    open_frame(1'b0);
    @(negedge clk); idle_in(); wide_i = 1; byte_vld_i = 1; byte_i = 8'h77;
    quiet();
    chk("R10 narrow frame kept narrow", dec_vld_o, match_o, 1'b1, 1'b1);
    open_frame(1'b1);
    @(negedge clk); idle_in(); wide_i = 0; byte_vld_i = 1; byte_i = 8'h77;
    quiet();
    chk("R10 wide frame waits", dec_vld_o, match_o, 1'b0, 1'b0);
    put_byte(8'h11);
    quiet();
    chk("R10 wide frame decides", dec_vld_o, match_o, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule